// File: doc/BRIEF.md
# Multi-Line Atomic Event Tracker

This block follows one atomic event for a single core when that event spans several cache lines. The core marks each line it wants in the event with a locked load or a locked prefetch. The tracker keeps the set of those line addresses and watches requests that other agents place on a snoop port. Before the event commits, a conflicting request does not stall anyone. It only records that the event has been spoiled.

The core ends the event in one of two ways. The first is an interference query, which is also the commit decision. If nothing has spoiled the event when the query is issued, the event commits. From then on the block refuses every conflicting snoop with a NACK, whatever the priority of the requester, so the core is sure to finish its stores. The second way is to go straight to the locked store, which then acts as the commit point and closes the event. An event that needs more lines than the tracker holds always fails. An abort also ends the event. On every failure the whole line set is released at once.

Ordinary loads and stores, such as stack traffic, never reach this block. They take no tracker slot.

Top module: `atomic_event_tracker`

## Requirements
- R1: After reset, and after any event ends, the block is idle: `evt_active`, `evt_committed` and `snp_nack` are low. A locked load (`cmd_op`=0) issued while idle starts an event with an empty line set and a clear interference flag. It is answered with `rsp_ok`=1 one cycle later, and `evt_active` rises in that same cycle.
- R2: Line addresses are compared with the low `LINE_OFF_W` offset bits ignored. A repeated locked load or locked prefetch (`cmd_op`=1) to a line already held takes no new slot and is answered `rsp_ok`=1. This holds even when its byte offset differs.
- R3: A locked access to a new distinct line while `MAX_LINES` lines are already held fails the event. The response is `rsp_ok`=0 and the block returns to idle. A later locked store (`cmd_op`=3) is then also answered `rsp_ok`=0.
- R4: Before commit, a snooped write (`snp_write`=1) to a held line sets a sticky interference flag. So does a snooped read to a held line that was marked with `cmd_wr`=1. A snooped read of a line that was never marked for writing, or any snoop to a line that is not held, leaves the flag clear.
- R5: An interference query (`cmd_op`=2) reflects the flag as it stands when the query is issued. If the flag is clear, the query returns `rsp_ok`=1 and the event commits (`evt_committed`=1). If the flag is set, the query returns `rsp_ok`=0 and the event fails.
- R6: While the event is committed, `snp_nack` is asserted in the same cycle as any conflicting snoop, as defined in R4, to a held line. Lines added by locked prefetch are covered. Non-conflicting snoops are not refused.
- R7: No snoop receives a NACK before the event commits.
- R8: A locked store closes the event and returns the block to idle. After a clean commit it answers `rsp_ok`=1. Without an earlier query, it answers `rsp_ok`=1 only if no interference occurred.
- R9: An abort (`cmd_op`=4) or any failure releases all held lines at once. After that, and after a locked store completes, no snoop is refused. A locked store or a query issued while idle answers `rsp_ok`=0.
- R10: A locked load issued during an active event adds to that event and does not start a new one. An interference flag that is already set stays set.
- R11: After commit, a locked access to a line already held answers `rsp_ok`=1 and the event stays committed. A locked access to a line not held fails the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core command strobe |
| cmd_op | input | 3 | 0 locked load, 1 locked prefetch, 2 interference query, 3 locked store, 4 abort |
| cmd_addr | input | ADDR_W | Byte address of the locked access |
| cmd_wr | input | 1 | The event intends to write the addressed line |
| rsp_valid | output | 1 | Response strobe, one cycle after a command |
| rsp_ok | output | 1 | 1 = success, 0 = event failed or command refused |
| snp_valid | input | 1 | Snooped request from another agent |
| snp_addr | input | ADDR_W | Byte address of the snooped request |
| snp_write | input | 1 | Snooped request is a write |
| snp_nack | output | 1 | Refuse the snooped request (same cycle) |
| evt_active | output | 1 | An event is open or committed |
| evt_committed | output | 1 | The event has committed |

## Verification
The bench builds the block with the default parameters: 32-bit addresses, 64-byte lines and eight slots. With eight slots, the ninth distinct line can be reached within a short directed sequence, mixed with repeats at other offsets that must not consume slots. The 6-bit offset lets the bench touch one line at offsets 0, 4 and 8 and check that they are treated as one line. Each scenario then exercises one way an event can end: a clean query, a spoiled query, a store used as the commit point, an abort, an overflow, and a locked access to a new line after commit.

// File: rtl/aet_pkg.sv
package aet_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_PREFETCH = 3'd1,
        OP_QUERY    = 3'd2,
        OP_STORE    = 3'd3,
        OP_ABORT    = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOCKED = 2'd2
    } evt_state_e;

    typedef struct packed {
        logic clr;
        logic ins;
    } set_ctl_t;

    function automatic logic is_locked_access(input logic [2:0] op);
        return (op == OP_LOAD) || (op == OP_PREFETCH);
    endfunction

endpackage

// File: rtl/aet_line_set.sv
module aet_line_set #(
    parameter int N  = 8,
    parameter int LW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  aet_pkg::set_ctl_t ctl,
    input  logic [LW-1:0] core_line,
    input  logic          core_wr,
    output logic          core_hit,
    output logic          full,
    input  logic [LW-1:0] snp_line,
    output logic          snp_hit,
    output logic          snp_hit_wr
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  vld;
    logic [N-1:0]  wr;
    logic [N-1:0]  cmatch;
    logic [N-1:0]  smatch;
    logic [CW-1:0] cnt;

    assign core_hit   = |cmatch;
    assign full       = (cnt == CW'(N));
    assign snp_hit    = |smatch;
    assign snp_hit_wr = |(smatch & wr);

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            logic          v_q;
            logic          w_q;
            logic [LW-1:0] t_q;
            logic          alloc;

            assign vld[g]    = v_q;
            assign wr[g]     = w_q;
            assign cmatch[g] = v_q && (t_q == core_line);
            assign smatch[g] = v_q && (t_q == snp_line);
            assign alloc     = ctl.ins && !core_hit && !full && (cnt == CW'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    w_q <= 1'b0;
                    t_q <= '0;
                end else if (ctl.clr) begin
                    v_q <= ctl.ins && (g == 0);
                    w_q <= ctl.ins && (g == 0) && core_wr;
                    if (g == 0) t_q <= core_line;
                end else if (ctl.ins && cmatch[g]) begin
                    w_q <= w_q | core_wr;
                end else if (alloc) begin
                    v_q <= 1'b1;
                    w_q <= core_wr;
                    t_q <= core_line;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ctl.clr)
            cnt <= ctl.ins ? CW'(1) : '0;
        else if (ctl.ins && !core_hit && !full)
            cnt <= cnt + CW'(1);
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmatch) && $onehot0(smatch));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt <= CW'(N)) && ($countones(vld) == int'(cnt)));

endmodule

// File: rtl/aet_ctrl.sv
module aet_ctrl
    import aet_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic     core_hit,
    input  logic     full,
    input  logic     snp_valid,
    input  logic     snp_write,
    input  logic     snp_hit,
    input  logic     snp_hit_wr,
    output set_ctl_t ctl,
    output logic     rsp_valid,
    output logic     rsp_ok,
    output logic     snp_nack,
    output logic     evt_active,
    output logic     evt_committed
);
    evt_state_e st_q, st_d;
    logic flag_q, flag_d;
    logic ok_d;
    logic conflict, interf_now, lock_acc;

    assign conflict   = snp_valid && snp_hit && (snp_write || snp_hit_wr);
    assign interf_now = flag_q || conflict;
    assign lock_acc   = cmd_valid && is_locked_access(cmd_op);

    always_comb begin
        st_d    = st_q;
        flag_d  = flag_q;
        ok_d    = 1'b0;
        ctl.clr = 1'b0;
        ctl.ins = 1'b0;
        if (st_q == ST_OPEN && conflict) flag_d = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid && cmd_op == OP_LOAD) begin
                    ctl.clr = 1'b1;
                    ctl.ins = 1'b1;
                    flag_d  = 1'b0;
                    ok_d    = 1'b1;
                    st_d    = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (lock_acc) begin
                    if (core_hit || !full) begin
                        ctl.ins = 1'b1;
                        ok_d    = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (cmd_valid) begin
                    case (cmd_op)
                        OP_QUERY: begin
                            ok_d = !interf_now;
                            st_d = interf_now ? ST_IDLE : ST_LOCKED;
                        end
                        OP_STORE: begin
                            ok_d = !interf_now;
                            st_d = ST_IDLE;
                        end
                        OP_ABORT: st_d = ST_IDLE;
                        default: ;
                    endcase
                end
            end
            ST_LOCKED: begin
                if (lock_acc) begin
                    if (core_hit) begin
                        ctl.ins = 1'b1;
                        ok_d    = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (cmd_valid) begin
                    case (cmd_op)
                        OP_QUERY: ok_d = 1'b1;
                        OP_STORE: begin
                            ok_d = 1'b1;
                            st_d = ST_IDLE;
                        end
                        OP_ABORT: st_d = ST_IDLE;
                        default: ;
                    endcase
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (st_q != ST_IDLE && st_d == ST_IDLE) begin
            ctl.clr = 1'b1;
            ctl.ins = 1'b0;
            flag_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            flag_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            st_q      <= st_d;
            flag_q    <= flag_d;
            rsp_valid <= cmd_valid;
            rsp_ok    <= cmd_valid && ok_d;
        end
    end

    assign snp_nack      = (st_q == ST_LOCKED) && conflict;
    assign evt_active    = (st_q != ST_IDLE);
    assign evt_committed = (st_q == ST_LOCKED);

    assert_start_clean_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && cmd_valid && cmd_op == OP_LOAD) |=> (st_q == ST_OPEN && !flag_q));

    assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OPEN && flag_q) |=> (flag_q || st_q == ST_IDLE));

    assert_commit_clean_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_committed) |-> ($past(cmd_op) == OP_QUERY && !$past(flag_q) && !$past(conflict)));

    assert_nack_tracked_R6: assert property (@(posedge clk) disable iff (rst)
        snp_nack |-> snp_hit);

    assert_store_closes_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_STORE) |=> !evt_active);

    assert_fail_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> !evt_active);

endmodule

// File: rtl/atomic_event_tracker.sv
module atomic_event_tracker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    parameter int MAX_LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wr,
    output logic              rsp_valid,
    output logic              rsp_ok,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_write,
    output logic              snp_nack,
    output logic              evt_active,
    output logic              evt_committed
);
    localparam int LW = ADDR_W - LINE_OFF_W;

    aet_pkg::set_ctl_t ctl;
    logic core_hit, full, snp_hit, snp_hit_wr;
    logic [LW-1:0] core_line, snp_line;

    assign core_line = cmd_addr[ADDR_W-1:LINE_OFF_W];
    assign snp_line  = snp_addr[ADDR_W-1:LINE_OFF_W];

    wire unused_offsets = ^{cmd_addr[LINE_OFF_W-1:0], snp_addr[LINE_OFF_W-1:0]};

    aet_line_set #(.N(MAX_LINES), .LW(LW)) u_set (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .core_line  (core_line),
        .core_wr    (cmd_wr),
        .core_hit   (core_hit),
        .full       (full),
        .snp_line   (snp_line),
        .snp_hit    (snp_hit),
        .snp_hit_wr (snp_hit_wr)
    );

    aet_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .core_hit      (core_hit),
        .full          (full),
        .snp_valid     (snp_valid),
        .snp_write     (snp_write),
        .snp_hit       (snp_hit),
        .snp_hit_wr    (snp_hit_wr),
        .ctl           (ctl),
        .rsp_valid     (rsp_valid),
        .rsp_ok        (rsp_ok),
        .snp_nack      (snp_nack),
        .evt_active    (evt_active),
        .evt_committed (evt_committed)
    );

    assert_nack_needs_commit_R7: assert property (@(posedge clk) disable iff (rst)
        snp_nack |-> (evt_committed && snp_valid));

endmodule

// File: tb/tb_atomic_event_tracker.sv
`timescale 1ns/1ps
module tb_atomic_event_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic        cmd_wr;
    logic        rsp_valid, rsp_ok;
    logic        snp_valid;
    logic [31:0] snp_addr;
    logic        snp_write;
    logic        snp_nack, evt_active, evt_committed;

    int n_total = 0;
    int n_fail  = 0;

    localparam logic [2:0] LD = 3'd0, PF = 3'd1, QY = 3'd2, ST = 3'd3, AB = 3'd4;

    always #10 clk = ~clk;

    atomic_event_tracker dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_write(snp_write),
        .snp_nack(snp_nack), .evt_active(evt_active), .evt_committed(evt_committed)
    );

    function automatic logic [31:0] ln(input int i, input int off);
        return 32'h0000_1000 + 32'(i * 64 + off);
    endfunction

    task automatic check(input logic act, input logic exp, input string what);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] a, input logic w, output logic ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wr = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        ok = rsp_valid && rsp_ok;
    endtask

    task automatic snoop(input logic [31:0] a, input logic w, output logic nack);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a; snp_write = w;
        #2 nack = snp_nack;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(evt_active, 1'b0, "R1 reset active");
        check(evt_committed, 1'b0, "R1 reset committed");
        check(rsp_valid, 1'b0, "R1 reset rsp_valid");
    endtask

    task automatic t_clean_commit;
        logic ok, nk;
        cmd(ST, ln(0, 0), 1'b0, ok);   check(ok, 1'b0, "R9 store while idle");
        cmd(QY, ln(0, 0), 1'b0, ok);   check(ok, 1'b0, "R9 query while idle");
        cmd(LD, ln(0, 0), 1'b0, ok);   check(ok, 1'b1, "R1 start ok");
        check(evt_active, 1'b1, "R1 active after start");
        snoop(ln(0, 8), 1'b1, nk);     check(nk, 1'b0, "R7 no nack before commit");
        cmd(AB, 32'h0, 1'b0, ok);      check(evt_active, 1'b0, "R9 abort idles");
        cmd(LD, ln(0, 0), 1'b0, ok);
        cmd(QY, 32'h0, 1'b0, ok);      check(ok, 1'b1, "R5 clean query");
        check(evt_committed, 1'b1, "R5 committed");
        snoop(ln(0, 4), 1'b1, nk);     check(nk, 1'b1, "R6 write to held line nacked");
        snoop(ln(0, 4), 1'b0, nk);     check(nk, 1'b0, "R6 read of read-only line");
        snoop(ln(5, 0), 1'b1, nk);     check(nk, 1'b0, "R6 untracked write");
        cmd(LD, ln(0, 8), 1'b0, ok);   check(ok, 1'b1, "R11 held line after commit");
        check(evt_committed, 1'b1, "R11 still committed");
        cmd(ST, ln(0, 0), 1'b0, ok);   check(ok, 1'b1, "R8 store after commit");
        check(evt_active, 1'b0, "R8 idle after store");
        snoop(ln(0, 0), 1'b1, nk);     check(nk, 1'b0, "R9 no nack after store");
    endtask

    task automatic t_interference;
        logic ok, nk;
        cmd(LD, ln(1, 0), 1'b0, ok);
        cmd(LD, ln(2, 0), 1'b1, ok);
        snoop(ln(1, 0), 1'b0, nk);     check(nk, 1'b0, "R4 read of read-only line");
        snoop(ln(3, 0), 1'b1, nk);     check(nk, 1'b0, "R4 untracked write");
        cmd(QY, 32'h0, 1'b0, ok);      check(ok, 1'b1, "R4 no false interference");
        cmd(AB, 32'h0, 1'b0, ok);
        snoop(ln(1, 0), 1'b1, nk);     check(nk, 1'b0, "R9 no nack after abort");
        cmd(LD, ln(1, 0), 1'b0, ok);
        cmd(LD, ln(2, 0), 1'b1, ok);
        snoop(ln(2, 16), 1'b0, nk);    check(nk, 1'b0, "R7 spoiling read not nacked");
        cmd(LD, ln(4, 0), 1'b0, ok);   check(ok, 1'b1, "R10 load adds line");
        check(evt_active, 1'b1, "R10 event still open");
        cmd(QY, 32'h0, 1'b0, ok);      check(ok, 1'b0, "R4 read of write line spoils");
        check(evt_active, 1'b0, "R5 failed query idles");
    endtask

    task automatic t_store_commit;
        logic ok, nk;
        cmd(LD, ln(6, 0), 1'b0, ok);
        snoop(ln(6, 0), 1'b1, nk);
        cmd(ST, ln(6, 0), 1'b0, ok);   check(ok, 1'b0, "R8 store with interference");
        cmd(LD, ln(6, 0), 1'b0, ok);
        cmd(ST, ln(6, 0), 1'b0, ok);   check(ok, 1'b1, "R8 clean store commits");
        check(evt_active, 1'b0, "R8 store closes");
    endtask

    task automatic t_overflow;
        logic ok, all_ok;
        all_ok = 1'b1;
        cmd(LD, ln(10, 0), 1'b0, ok);
        for (int i = 1; i < 8; i++) begin
            cmd(PF, ln(10 + i, 0), 1'b0, ok); all_ok &= ok;
            cmd(LD, ln(10 + i - 1, 4), 1'b1, ok); all_ok &= ok;
        end
        check(all_ok, 1'b1, "R2 eight lines with repeats fit");
        check(evt_active, 1'b1, "R2 still active at eight");
        cmd(LD, ln(30, 0), 1'b0, ok);  check(ok, 1'b0, "R3 ninth line fails");
        check(evt_active, 1'b0, "R3 idle after overflow");
        cmd(ST, ln(10, 0), 1'b0, ok);  check(ok, 1'b0, "R3 later store fails");
    endtask

    task automatic t_prefetch;
        logic ok, nk;
        cmd(LD, ln(40, 0), 1'b0, ok);
        cmd(PF, ln(41, 0), 1'b1, ok);
        cmd(QY, 32'h0, 1'b0, ok);
        snoop(ln(41, 32), 1'b0, nk);   check(nk, 1'b1, "R6 prefetched write line nacked");
        cmd(PF, ln(42, 0), 1'b0, ok);  check(ok, 1'b0, "R11 new line after commit fails");
        check(evt_active, 1'b0, "R11 idle after fail");
        snoop(ln(41, 0), 1'b1, nk);    check(nk, 1'b0, "R9 lines released");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = '0; cmd_wr = 1'b0;
        snp_valid = 1'b0; snp_addr = '0; snp_write = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean_commit();
        t_interference();
        t_store_commit();
        t_overflow();
        t_prefetch();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule